// File: doc/BRIEF.md
# Scaled Index Add Unit

This unit is one slice of an integer execute stage. It forms an indexed address or array offset in a single step: the first source operand is shifted left by one to four places and the second source operand is added to it. The amount comes from a two-bit field of the instruction word, biased by one. Two widths share the datapath. The narrow form wraps its sum to 32 bits and sign-extends bit 31 across the whole 64-bit word. The wide form keeps all 64 bits. The wide form is only legal while the core runs in 64-bit mode.

The issue stage presents the instruction word, the two operand values already read from the register file, a revision-6 feature flag, a 64-bit mode flag and a valid strobe. The unit decodes the word and drives the register indices back combinationally for the read. One clock later it registers one of three outcomes: a write of the result to a destination register, a reserved-instruction exception, or a hand-off of the narrow function code to the legacy decoder when the feature flag is clear. If none of the three applies, the registered result keeps its last value.

Top module: `scaled_index_add`

## Requirements
- R1: With valid high, instr[31:26]=0, instr[5:0]=0x05, instr[10:8]=0 and r6_en=1, one clock later out_we=1 and out_result is the low 32 bits of ((src_a << (instr[7:6]+1)) + src_b), sign-extended from bit 31 to 64 bits.
- R2: With valid high, instr[31:26]=0, instr[5:0]=0x15, instr[10:8]=0, r6_en=1 and mode64=1, one clock later out_we=1 and out_result is the full 64-bit value (src_a << (instr[7:6]+1)) + src_b, taken modulo 2^64.
- R3: The shift amount is the field instr[7:6] plus one. Field values 0, 1, 2 and 3 therefore shift by 1, 2, 3 and 4 in both forms.
- R4: The 0x15 form with r6_en=1 and mode64=0 sets out_rsvd_exc one clock later and produces no write. At most one of out_we, out_rsvd_exc and out_legacy is high in any cycle.
- R5: Function code 0x05 under major opcode 0 with r6_en=0 sets out_legacy one clock later, whatever instr[10:8] holds, and produces neither a write nor an exception.
- R6: A recognised form whose destination field instr[15:11] is 0 produces out_we=0, and out_result keeps its previous value.
- R7: rs_idx equals instr[25:21] and rt_idx equals instr[20:16], both combinationally. When out_we is high, out_waddr equals the instr[15:11] that was presented one clock earlier.
- R8: No write, exception or hand-off happens, and out_result holds, in any of these cases: valid low, a nonzero major opcode, nonzero instr[10:8] on a recognised form, any other function code, or 0x15 with r6_en=0.
- R9: While rst_n is low, out_result, out_waddr, out_we, out_rsvd_exc and out_legacy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Operand that is shifted |
| src_b | input | 64 | Operand that is added |
| r6_en | input | 1 | Revision-6 feature flag |
| mode64 | input | 1 | 64-bit mode is active |
| rs_idx | output | 5 | Register index of the shifted operand |
| rt_idx | output | 5 | Register index of the added operand |
| out_result | output | 64 | Registered result |
| out_waddr | output | 5 | Registered destination index |
| out_we | output | 1 | Write the result this cycle |
| out_rsvd_exc | output | 1 | Reserved-instruction exception |
| out_legacy | output | 1 | Code 0x05 is passed to the legacy decoder |

## Verification
The register indices are combinational. The bench checks them one time step after it drives a word, inside the same cycle. The result, destination index, write enable, exception and hand-off flags all come from a single register stage, so each is due at the first rising edge after the stimulus. The bench drives on a falling edge and samples on the next falling edge, which lies after exactly one rising edge. A case that must not write is checked in that same sampled cycle: the bench confirms that the registered result still equals the value it expected from the last write.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned NARROW  = 32;
  localparam int unsigned SHW     = 2;
  localparam int unsigned RIDX    = 5;
  localparam int unsigned IW      = 32;

  localparam logic [5:0] MAJOR_SPECIAL = 6'h00;
  localparam logic [5:0] FN_NARROW     = 6'h05;
  localparam logic [5:0] FN_WIDE       = 6'h15;

  typedef enum logic [2:0] {
    K_NONE,
    K_NARROW,
    K_WIDE,
    K_RSVD,
    K_LEGACY
  } sia_kind_e;
endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
(
  input  logic [IW-1:0]   instr,
  input  logic            r6_en,
  input  logic            mode64,
  output sia_kind_e       kind,
  output logic [SHW-1:0]  sh,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] rd
);
  logic [5:0] major;
  logic [5:0] fn;
  logic       pad_zero;

  assign major    = instr[31:26];
  assign fn       = instr[5:0];
  assign pad_zero = (instr[10:8] == 3'b000);
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign rd       = instr[15:11];
  assign sh       = instr[7:6];

  always_comb begin
    kind = K_NONE;
    if (major == MAJOR_SPECIAL) begin
      if (fn == FN_NARROW) begin
        if (!r6_en)        kind = K_LEGACY;
        else if (pad_zero) kind = K_NARROW;
      end else if (fn == FN_WIDE && r6_en && pad_zero) begin
        kind = mode64 ? K_WIDE : K_RSVD;
      end
    end
  end
endmodule

// File: rtl/sia_shift_add.sv
module sia_shift_add #(
  parameter int unsigned XW   = 64,
  parameter int unsigned SW   = 2,
  parameter int unsigned KEEP = 64
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic [SW-1:0] sh,
  output logic [XW-1:0] y
);
  localparam int unsigned AW = SW + 1;

  logic [AW-1:0] amt;
  logic [XW-1:0] sum;

  assign amt = {1'b0, sh} + AW'(1);
  assign sum = (a << amt) + b;

  generate
    if (KEEP < XW) begin : g_sext
      assign y = {{(XW-KEEP){sum[KEEP-1]}}, sum[KEEP-1:0]};
    end else begin : g_full
      assign y = sum;
    end
  endgenerate
endmodule

// File: rtl/sia_out_reg.sv
module sia_out_reg #(
  parameter int unsigned XW = 64,
  parameter int unsigned RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_d,
  input  logic          exc_d,
  input  logic          leg_d,
  input  logic [XW-1:0] res_d,
  input  logic [RW-1:0] waddr_d,
  output logic          we_q,
  output logic          exc_q,
  output logic          leg_q,
  output logic [XW-1:0] res_q,
  output logic [RW-1:0] waddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      exc_q <= 1'b0;
      leg_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      exc_q <= exc_d;
      leg_q <= leg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      waddr_q <= '0;
    end else if (we_d) begin
      res_q   <= res_d;
      waddr_q <= waddr_d;
    end
  end
endmodule

// File: rtl/scaled_index_add.sv
module scaled_index_add
  import sia_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [31:0]     instr,
  input  logic [63:0]     src_a,
  input  logic [63:0]     src_b,
  input  logic            r6_en,
  input  logic            mode64,
  output logic [4:0]      rs_idx,
  output logic [4:0]      rt_idx,
  output logic [63:0]     out_result,
  output logic [4:0]      out_waddr,
  output logic            out_we,
  output logic            out_rsvd_exc,
  output logic            out_legacy
);
  localparam int unsigned NFORM = 2;

  sia_kind_e       kind;
  logic [SHW-1:0]  sh;
  logic [RIDX-1:0] rd;
  logic [XLEN-1:0] form_y [NFORM];
  logic            we_n;
  logic            exc_n;
  logic            leg_n;
  logic [XLEN-1:0] res_n;

  sia_decode u_dec (
    .instr  (instr),
    .r6_en  (r6_en),
    .mode64 (mode64),
    .kind   (kind),
    .sh     (sh),
    .rs     (rs_idx),
    .rt     (rt_idx),
    .rd     (rd)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NFORM; gi++) begin : g_form
      sia_shift_add #(
        .XW   (XLEN),
        .SW   (SHW),
        .KEEP ((gi == 0) ? NARROW : XLEN)
      ) u_sa (
        .a  (src_a),
        .b  (src_b),
        .sh (sh),
        .y  (form_y[gi])
      );
    end
  endgenerate

  always_comb begin
    we_n  = valid && (kind == K_NARROW || kind == K_WIDE) && (rd != '0);
    exc_n = valid && (kind == K_RSVD);
    leg_n = valid && (kind == K_LEGACY);
    res_n = (kind == K_WIDE) ? form_y[1] : form_y[0];
  end

  sia_out_reg #(.XW(XLEN), .RW(RIDX)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_d    (we_n),
    .exc_d   (exc_n),
    .leg_d   (leg_n),
    .res_d   (res_n),
    .waddr_d (rd),
    .we_q    (out_we),
    .exc_q   (out_rsvd_exc),
    .leg_q   (out_legacy),
    .res_q   (out_result),
    .waddr_q (out_waddr)
  );
endmodule

// File: rtl/sia_checker.sv
module sia_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic [31:0] instr,
  input logic        r6_en,
  input logic        mode64,
  input logic [63:0] out_result,
  input logic [4:0]  out_waddr,
  input logic        out_we,
  input logic        out_rsvd_exc,
  input logic        out_legacy
);
  // R4: the three outcomes exclude each other
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_we, out_rsvd_exc, out_legacy}));

  // R4: an exception only follows a wide form issued outside 64-bit mode
  assert_exc_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsvd_exc |-> ($past(valid) && !$past(mode64) && $past(instr[5:0]) == 6'h15));

  // R5: a hand-off only follows the narrow code with the feature flag clear
  assert_legacy_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_legacy |-> ($past(valid) && !$past(r6_en) && $past(instr[5:0]) == 6'h05));

  // R6: a write never targets register 0
  assert_no_zero_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_waddr != 5'd0));

  // R1: a narrow result is sign-extended from bit 31
  assert_narrow_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && $past(instr[5:0]) == 6'h05) |-> (out_result[63:32] == {32{out_result[31]}}));

  // R8: without a write the result holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |-> $stable(out_result));

  // R7: the destination index follows the word issued one clock earlier
  assert_waddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_waddr == $past(instr[15:11])));
endmodule

bind scaled_index_add sia_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid        (valid),
  .instr        (instr),
  .r6_en        (r6_en),
  .mode64       (mode64),
  .out_result   (out_result),
  .out_waddr    (out_waddr),
  .out_we       (out_we),
  .out_rsvd_exc (out_rsvd_exc),
  .out_legacy   (out_legacy)
);

// File: tb/scaled_index_add_test.sv
module scaled_index_add_test;
  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [31:0] instr;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        r6_en;
  logic        mode64;
  logic [4:0]  rs_idx;
  logic [4:0]  rt_idx;
  logic [63:0] out_result;
  logic [4:0]  out_waddr;
  logic        out_we;
  logic        out_rsvd_exc;
  logic        out_legacy;

  int checks;
  int failures;
  bit done;
  logic [63:0] last_res;

  scaled_index_add uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .r6_en(r6_en), .mode64(mode64),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .out_result(out_result),
    .out_waddr(out_waddr), .out_we(out_we), .out_rsvd_exc(out_rsvd_exc),
    .out_legacy(out_legacy)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] major, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd,
                                     input logic [2:0] pad, input logic [1:0] sh,
                                     input logic [5:0] fn);
    return {major, rs, rt, rd, pad, sh, fn};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] w, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] s;
    s = (a << (int'(w[7:6]) + 1)) + b;
    if (w[5:0] == 6'h05) return {{32{s[31]}}, s[31:0]};
    return s;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic r6, input logic m64,
                       input logic v, input logic e_we, input logic e_exc,
                       input logic e_leg);
    logic [63:0] e_res;
    valid = v; instr = w; src_a = a; src_b = b; r6_en = r6; mode64 = m64;
    #1;
    chk("R7", "rs_idx", 64'(rs_idx), 64'(w[25:21]));
    chk("R7", "rt_idx", 64'(rt_idx), 64'(w[20:16]));
    e_res = e_we ? model(w, a, b) : last_res;
    @(negedge clk);
    chk(req, "we", 64'(out_we), 64'(e_we));
    chk(req, "exc", 64'(out_rsvd_exc), 64'(e_exc));
    chk(req, "legacy", 64'(out_legacy), 64'(e_leg));
    chk(req, "result", out_result, e_res);
    if (e_we) chk("R7", "waddr", 64'(out_waddr), 64'(w[15:11]));
    last_res = e_res;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa [6];
    logic [63:0] pb [6];
    checks = 0; failures = 0; done = 0; last_res = '0;
    pa[0] = 64'h0000_0000_0000_0001; pb[0] = 64'h0000_0000_0000_0000;
    pa[1] = 64'h0000_0000_1FFF_FFFF; pb[1] = 64'h0000_0000_0000_0003;
    pa[2] = 64'hFFFF_FFFF_FFFF_FFFF; pb[2] = 64'h0000_0000_0000_0010;
    pa[3] = 64'h1234_5678_9ABC_DEF0; pb[3] = 64'h0FED_CBA9_8765_4321;
    pa[4] = 64'h8000_0000_0000_0000; pb[4] = 64'hFFFF_FFFF_FFFF_FFFF;
    pa[5] = 64'h0000_0000_4000_0000; pb[5] = 64'h0000_0000_7FFF_FFFF;
    valid = 0; instr = '0; src_a = '0; src_b = '0; r6_en = 0; mode64 = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R9", "reset result", out_result, 64'd0);
    chk("R9", "reset waddr", 64'(out_waddr), 64'd0);
    chk("R9", "reset flags", 64'({out_we, out_rsvd_exc, out_legacy}), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1, R2, R3: sweep both forms over every shift field and operand pattern
    for (int sh = 0; sh < 4; sh++) begin
      for (int p = 0; p < 6; p++) begin
        issue("R1", mk(6'h00, 5'd3, 5'd4, 5'(p + 1), 3'd0, 2'(sh), 6'h05),
              pa[p], pb[p], 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        issue("R2", mk(6'h00, 5'd7, 5'd9, 5'(p + 10), 3'd0, 2'(sh), 6'h15),
              pa[p], pb[p], 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      end
    end
    // R3: shift by 4 of a unit operand gives 16
    issue("R3", mk(6'h00, 5'd1, 5'd2, 5'd5, 3'd0, 2'd3, 6'h15),
          64'd1, 64'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3", "shift by four", out_result, 64'd16);
    // R1: narrow form also legal in 64-bit mode
    issue("R1", mk(6'h00, 5'd1, 5'd2, 5'd6, 3'd0, 2'd0, 6'h05),
          64'h0000_0000_4000_0000, 64'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1", "sign extended", out_result, 64'hFFFF_FFFF_8000_0000);
    // R4: wide form outside 64-bit mode
    issue("R4", mk(6'h00, 5'd1, 5'd2, 5'd6, 3'd0, 2'd1, 6'h15),
          64'd5, 64'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R5: narrow code with feature flag clear, with and without padding bits
    issue("R5", mk(6'h00, 5'd1, 5'd2, 5'd6, 3'd0, 2'd1, 6'h05),
          64'd5, 64'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    issue("R5", mk(6'h00, 5'd1, 5'd2, 5'd6, 3'd5, 2'd1, 6'h05),
          64'd5, 64'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R6: destination 0 writes nothing
    issue("R6", mk(6'h00, 5'd1, 5'd2, 5'd0, 3'd0, 2'd2, 6'h05),
          64'd9, 64'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R6", mk(6'h00, 5'd1, 5'd2, 5'd0, 3'd0, 2'd2, 6'h15),
          64'd9, 64'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8: cases that must do nothing
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd0, 2'd2, 6'h05),
          64'd3, 64'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h01, 5'd1, 5'd2, 5'd8, 3'd0, 2'd2, 6'h05),
          64'd3, 64'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd1, 2'd2, 6'h05),
          64'd3, 64'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd4, 2'd2, 6'h15),
          64'd3, 64'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd0, 2'd2, 6'h25),
          64'd3, 64'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd0, 2'd2, 6'h15),
          64'd3, 64'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue("R8", mk(6'h00, 5'd1, 5'd2, 5'd8, 3'd0, 2'd2, 6'h15),
          64'd3, 64'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: index extraction over all register numbers
    for (int r = 1; r < 32; r++) begin
      issue("R7", mk(6'h00, 5'(r), 5'(31 - r), 5'(r), 3'd0, 2'(r % 4), 6'h15),
            64'(r), 64'(r * 3), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    end
    // R9: reset in mid-run clears the outputs
    rst_n = 0;
    #1;
    chk("R9", "mid reset result", out_result, 64'd0);
    chk("R9", "mid reset flags", 64'({out_we, out_rsvd_exc, out_legacy}), 64'd0);
    valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule